// File: doc/BRIEF.md
# Timed SPI DAC Refresh Sequencer

This block keeps the output codes of up to four external SPI DACs current without any per-sample work by a processor. Each channel has its own interval timer. When a timer expires, the channel is queued. A single sequencer then performs a fixed series of steps for that channel:

1. The channel's select line goes low.
2. A 16-bit sample is shifted out in SPI mode 0, MSB first.
3. The DAC load strobe is pulsed. It stays low while the channel's next period is copied into its timer and while the select is released.
4. The load strobe is released and a one-cycle completion pulse is raised.

The host writes sample words and periods through a small write port. Sample writes go into a staging register per channel. Staged values move into the active sample registers only while the sequencer is idle, so a frame in flight is never corrupted. Period writes go into a shadow register. The timer adopts the shadow value at the reload step of that channel's next sequence.

When several channels are queued, the lowest index is served first. The next queued channel starts right after the current sequence ends. If a timer expires again while its previous request is still waiting, a sticky overrun flag is set for that channel.

Top module: `dac_refresh_seq`

## Requirements
- R1: After reset every select and load strobe output is high, the bit clock is low, and the completion pulse and overrun flags are 0. While a channel's timer enable is low, that channel produces no frame, even if it has a period programmed.
- R2: Each expiry sends exactly one 16-bit frame on the selected channel in SPI mode 0. MOSI is stable at the rising bit-clock edge, and bits go out MSB first. The bit clock stays high for `half_div` system cycles and low for `half_div` system cycles; a `half_div` of 0 behaves as 1.
- R3: Step order is fixed: the select goes low, the frame is sent, the load strobe goes low while the select is still low, the select returns high while the load strobe is still low, and then the load strobe returns high. The load strobe is low for exactly 3 system cycles. At most one select and at most one load strobe are ever low at the same time.
- R4: `done_irq` is high for exactly one cycle, in the cycle where the load strobe is released. In that cycle `done_ch` gives the served channel, and all selects and strobes are high.
- R5: An enabled channel with period P (P larger than one sequence) starts its select-low edges exactly P cycles apart.
- R6: A period write (`host_sel`=1) only updates the shadow register. The timer adopts it at the reload step of the channel's next sequence. The interval that starts at the first expiry after that reload is the first to use the new period.
- R7: A sample write (`host_sel`=0) does not change a frame that is already in progress. The latest staged value is the one sent by the channel's next sequence.
- R8: Channels that expire in the same cycle are served lowest index first. The second channel's select goes low 3 cycles after the first channel's select returns high.
- R9: `ovr_flag[i]` is set when channel i's timer expires while its previous request has not yet started. It stays set until `ovr_clr[i]` is pulsed. It stays 0 when the period is longer than one sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_en | input | NCH | Per-channel timer enable |
| half_div | input | DIVW | Bit-clock half period in system cycles (0 is treated as 1) |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 1 | Write target: 0 = staged sample, 1 = period shadow |
| host_ch | input | CHW | Channel addressed by the write |
| host_wdata | input | DW | Write data (a period uses the low PW bits) |
| ovr_clr | input | NCH | Per-channel overrun clear pulse |
| spi_sclk | output | 1 | SPI bit clock |
| spi_mosi | output | 1 | SPI serial data |
| dac_cs_n | output | NCH | Per-channel active-low select |
| dac_ld_n | output | NCH | Per-channel active-low DAC load strobe |
| done_irq | output | 1 | One-cycle completion pulse |
| done_ch | output | CHW | Channel whose sequence just completed |
| ovr_flag | output | NCH | Sticky per-channel overrun flags |

## Verification
A corrupted sequencer state shows within one sequence at the ports. The symptoms are:
- two selects or two strobes low at once;
- a load strobe pulse of the wrong width;
- a frame without exactly 16 rising clock edges;
- a completion pulse while a line is still active.

A wrong timer count or a mistimed period reload shows as a change in the spacing of select-low edges. It is measured one or two periods after the stimulus.

A staging error shows as a wrong word in the frame that was in flight, or in the frame after it. A wrong pending bit shows as the wrong service order or as an overrun flag in the wrong state.

// File: rtl/dacseq_pkg.sv
package dacseq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_SHIFT,
        ST_LATCH,
        ST_RELOAD,
        ST_DESEL,
        ST_REL
    } seq_state_e;
endpackage

// File: rtl/dacseq_timer.sv
module dacseq_timer #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [PW-1:0] per_shd,
    input  logic          reload,
    output logic          expire
);
    typedef struct packed {
        logic [PW-1:0] cnt;
        logic [PW-1:0] per;
    } tmr_s;

    tmr_s q, d;

    assign expire = en && (q.cnt == '0);

    always_comb begin
        d = q;
        if (!en) begin
            // disabled: follow the shadow so the first interval uses it
            d.per = per_shd;
            d.cnt = per_shd - PW'(1);
        end else begin
            if (reload) begin
                d.per = per_shd;
            end
            if (q.cnt == '0) begin
                d.cnt = q.per - PW'(1);
            end else begin
                d.cnt = q.cnt - PW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/dacseq_spi.sv
module dacseq_spi #(
    parameter int DW   = 16,
    parameter int DIVW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [DW-1:0]   data,
    input  logic [DIVW-1:0] half,
    output logic            sclk,
    output logic            mosi,
    output logic            last
);
    localparam int CNTW = $clog2(DW);

    typedef struct packed {
        logic            act;
        logic            ph;
        logic [DIVW-1:0] div;
        logic [CNTW-1:0] cnt;
        logic [DW-1:0]   sh;
    } spi_s;

    spi_s q, d;
    logic [DIVW-1:0] half_eff;
    logic            tick;

    assign half_eff = (half == '0) ? DIVW'(1) : half;
    assign tick     = q.act && (q.div == half_eff - DIVW'(1));
    assign last     = tick && q.ph && (q.cnt == CNTW'(DW - 1));
    assign sclk     = q.act && q.ph;
    assign mosi     = q.act && q.sh[DW-1];

    always_comb begin
        d = q;
        if (load) begin
            d.act = 1'b1;
            d.ph  = 1'b0;
            d.div = '0;
            d.cnt = '0;
            d.sh  = data;
        end else if (q.act) begin
            if (tick) begin
                d.div = '0;
                d.ph  = !q.ph;
                if (q.ph) begin
                    // falling edge: present the next bit
                    d.sh  = {q.sh[DW-2:0], 1'b0};
                    d.cnt = q.cnt + CNTW'(1);
                    if (q.cnt == CNTW'(DW - 1)) begin
                        d.act = 1'b0;
                    end
                end
            end else begin
                d.div = q.div + DIVW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/dacseq_prio.sv
module dacseq_prio #(
    parameter int N   = 4,
    parameter int CHW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]   req,
    output logic           any,
    output logic [CHW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        // scan downward so the lowest set index is the one kept
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = CHW'(i);
            end
        end
    end
endmodule

// File: rtl/dac_refresh_seq.sv
module dac_refresh_seq
    import dacseq_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int DW   = 16,
    parameter int PW   = 16,
    parameter int DIVW = 4,
    parameter int CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  tmr_en,
    input  logic [DIVW-1:0] half_div,
    input  logic            host_we,
    input  logic            host_sel,
    input  logic [CHW-1:0]  host_ch,
    input  logic [DW-1:0]   host_wdata,
    input  logic [NCH-1:0]  ovr_clr,
    output logic            spi_sclk,
    output logic            spi_mosi,
    output logic [NCH-1:0]  dac_cs_n,
    output logic [NCH-1:0]  dac_ld_n,
    output logic            done_irq,
    output logic [CHW-1:0]  done_ch,
    output logic [NCH-1:0]  ovr_flag
);
    typedef struct packed {
        seq_state_e                st;
        logic [CHW-1:0]            ch;
        logic [NCH-1:0]            pend;
        logic [NCH-1:0]            ovr;
        logic [NCH-1:0]            stgv;
        logic [NCH-1:0][DW-1:0]    stg;
        logic [NCH-1:0][DW-1:0]    act;
        logic [NCH-1:0][PW-1:0]    per;
    } seq_s;

    seq_s q, d;

    logic [NCH-1:0] expire;
    logic [NCH-1:0] reload;
    logic           req_any;
    logic [CHW-1:0] req_idx;
    logic           shift_last;
    logic           grant;

    dacseq_prio #(.N(NCH), .CHW(CHW)) u_prio (
        .req (q.pend),
        .any (req_any),
        .idx (req_idx)
    );

    dacseq_spi #(.DW(DW), .DIVW(DIVW)) u_spi (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (q.st == ST_SEL),
        .data  (q.act[q.ch]),
        .half  (half_div),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi),
        .last  (shift_last)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        assign reload[g] = (q.st == ST_RELOAD) && (q.ch == CHW'(g));

        dacseq_timer #(.PW(PW)) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (tmr_en[g]),
            .per_shd (q.per[g]),
            .reload  (reload[g]),
            .expire  (expire[g])
        );

        assign dac_cs_n[g] = !((q.ch == CHW'(g)) &&
                               (q.st == ST_SEL || q.st == ST_SHIFT ||
                                q.st == ST_LATCH || q.st == ST_RELOAD));
        assign dac_ld_n[g] = !((q.ch == CHW'(g)) &&
                               (q.st == ST_LATCH || q.st == ST_RELOAD ||
                                q.st == ST_DESEL));
    end

    assign grant    = (q.st == ST_IDLE) && req_any;
    assign done_irq = (q.st == ST_REL);
    assign done_ch  = q.ch;
    assign ovr_flag = q.ovr;

    always_comb begin
        d = q;
        d.ovr = q.ovr & ~ovr_clr;

        // sequence boundary: commit staged samples, then serve a request
        if (q.st == ST_IDLE) begin
            for (int i = 0; i < NCH; i++) begin
                if (q.stgv[i]) begin
                    d.act[i]  = q.stg[i];
                    d.stgv[i] = 1'b0;
                end
            end
        end
        if (grant) begin
            d.pend[req_idx] = 1'b0;
            d.ch            = req_idx;
        end

        for (int i = 0; i < NCH; i++) begin
            if (expire[i]) begin
                if (q.pend[i] && !(grant && req_idx == CHW'(i))) begin
                    d.ovr[i] = 1'b1;
                end
                d.pend[i] = 1'b1;
            end
        end

        unique case (q.st)
            ST_IDLE:   if (grant) d.st = ST_SEL;
            ST_SEL:    d.st = ST_SHIFT;
            ST_SHIFT:  if (shift_last) d.st = ST_LATCH;
            ST_LATCH:  d.st = ST_RELOAD;
            ST_RELOAD: d.st = ST_DESEL;
            ST_DESEL:  d.st = ST_REL;
            ST_REL:    d.st = ST_IDLE;
            default:   d.st = ST_IDLE;
        endcase

        if (host_we) begin
            if (host_sel) begin
                d.per[host_ch] = host_wdata[PW-1:0];
            end else begin
                d.stg[host_ch]  = host_wdata;
                d.stgv[host_ch] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/dacseq_chk.sv
module dacseq_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           spi_sclk,
    input logic [NCH-1:0] dac_cs_n,
    input logic [NCH-1:0] dac_ld_n,
    input logic           done_irq,
    input logic [NCH-1:0] ovr_flag,
    input logic [NCH-1:0] ovr_clr
);
    logic cs_act;
    logic ld_act;
    assign cs_act = !(&dac_cs_n);
    assign ld_act = !(&dac_ld_n);

    assert_one_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~dac_cs_n));

    assert_one_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~dac_ld_n));

    assert_sclk_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> cs_act);

    assert_latch_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ld_act) |=> ld_act ##1 ld_act ##1 !ld_act);

    assert_latch_under_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ld_act) |-> cs_act);

    assert_deselect_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_act) |-> ld_act);

    assert_done_at_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> (!cs_act && !ld_act && $past(ld_act)));

    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);

    assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((~ovr_flag & $past(ovr_flag) & ~$past(ovr_clr)) == '0));
endmodule

bind dac_refresh_seq dacseq_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_sclk (spi_sclk),
    .dac_cs_n (dac_cs_n),
    .dac_ld_n (dac_ld_n),
    .done_irq (done_irq),
    .ovr_flag (ovr_flag),
    .ovr_clr  (ovr_clr)
);

// File: tb/tb_dac_refresh_seq.sv
module tb_dac_refresh_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  tmr_en = '0;
    logic [3:0]  half_div = 4'd1;
    logic        host_we = 1'b0;
    logic        host_sel = 1'b0;
    logic [1:0]  host_ch = '0;
    logic [15:0] host_wdata = '0;
    logic [3:0]  ovr_clr = '0;
    logic        spi_sclk, spi_mosi, done_irq;
    logic [3:0]  dac_cs_n, dac_ld_n, ovr_flag;
    logic [1:0]  done_ch;

    dac_refresh_seq dut (
        .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .half_div(half_div),
        .host_we(host_we), .host_sel(host_sel), .host_ch(host_ch),
        .host_wdata(host_wdata), .ovr_clr(ovr_clr), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .dac_cs_n(dac_cs_n), .dac_ld_n(dac_ld_n),
        .done_irq(done_irq), .done_ch(done_ch), .ovr_flag(ovr_flag)
    );

    always #2.5 clk = !clk;

    int nchk = 0, nfail = 0;
    bit ended = 0;

    // port monitor, sampled mid-cycle
    int        cyc = 0, nf = 0, ns = 0, dn = 0, ordbad = 0;
    int        fs_t [128];
    int        fr_t [128];
    int        fs_ch[128];
    int        fs_nb[128];
    logic [15:0] fs_d[128];
    logic [15:0] sh = '0;
    int        nb = 0, hw = 0, lasthw = 0, lw = 0, lastlw = 0;
    int        dch = 0;
    logic [3:0] pcs = 4'hF, pld = 4'hF;
    logic       psclk = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            for (int i = 0; i < 4; i++) begin
                if (pcs[i] && !dac_cs_n[i] && nf < 128) begin
                    fs_t[nf] = cyc; fs_ch[nf] = i; sh = '0; nb = 0; ns++;
                end
                if (!pcs[i] && dac_cs_n[i] && nf < 128) begin
                    fs_d[nf] = sh; fs_nb[nf] = nb; fr_t[nf] = cyc;
                    if (dac_ld_n[i]) ordbad++;
                    nf++;
                end
                if (pld[i] && !dac_ld_n[i] && dac_cs_n[i]) ordbad++;
            end
            if (spi_sclk && !psclk) begin
                sh = {sh[14:0], spi_mosi}; nb++;
            end
            if (spi_sclk) hw++;
            else if (psclk) begin lasthw = hw; hw = 0; end
            if (!(&dac_ld_n)) lw++;
            else if (!(&pld)) begin lastlw = lw; lw = 0; end
            if (done_irq) begin
                dn++; dch = done_ch;
                if (!(&dac_cs_n) || !(&dac_ld_n)) ordbad++;
            end
        end
        pcs = dac_cs_n; pld = dac_ld_n; psclk = spi_sclk;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hwr(input logic sel, input int ch, input logic [15:0] v);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_ch = 2'(ch); host_wdata = v;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic wait_done(input int k);
        int n0 = dn;
        int t = 0;
        while (dn < n0 + k && t < 20000) begin
            @(posedge clk); t++;
        end
        chk(dn >= n0 + k, "wait for completion", dn, n0 + k);
    endtask

    task automatic set_en(input logic [3:0] v);
        @(negedge clk); tmr_en = v;
    endtask

    localparam int NV = 5;
    localparam int          V_CH [NV] = '{0, 1, 2, 3, 0};
    localparam logic [15:0] V_SMP[NV] = '{16'hA5C3, 16'h8001, 16'h7FFE, 16'hFFFF, 16'h0000};
    localparam int          V_PER[NV] = '{200, 300, 150, 400, 100};
    localparam int          V_DIV[NV] = '{1, 2, 3, 4, 0};

    initial begin
        int b;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(&dac_cs_n, "R1 select idle in reset", dac_cs_n, 4'hF);
        chk(&dac_ld_n, "R1 strobe idle in reset", dac_ld_n, 4'hF);
        chk(!spi_sclk && !done_irq, "R1 clock/done low", {spi_sclk, done_irq}, 0);
        chk(ovr_flag == 0, "R1 overrun clear", ovr_flag, 0);
        rst_n = 1'b1;
        hwr(1'b1, 0, 16'd50);
        repeat (300) @(negedge clk);
        chk(nf == 0 && dn == 0, "R1 no frame while disabled", nf, 0);

        // R2 R3 R4: vector table walk
        for (int v = 0; v < NV; v++) begin
            half_div = 4'(V_DIV[v]);
            hwr(1'b1, V_CH[v], 16'(V_PER[v]));
            hwr(1'b0, V_CH[v], V_SMP[v]);
            set_en(4'b1 << V_CH[v]);
            wait_done(1);
            set_en(4'b0);
            repeat (20) @(negedge clk);
            chk(fs_d[nf-1] == V_SMP[v], "R2 frame data", fs_d[nf-1], V_SMP[v]);
            chk(fs_ch[nf-1] == V_CH[v], "R2 frame channel", fs_ch[nf-1], V_CH[v]);
            chk(fs_nb[nf-1] == 16, "R2 bit count", fs_nb[nf-1], 16);
            chk(lasthw == ((V_DIV[v] == 0) ? 1 : V_DIV[v]), "R2 clock high width", lasthw,
                (V_DIV[v] == 0) ? 1 : V_DIV[v]);
            chk(lastlw == 3, "R3 strobe width", lastlw, 3);
            chk(dch == V_CH[v], "R4 done channel", dch, V_CH[v]);
            chk(ordbad == 0, "R3 R4 step order", ordbad, 0);
        end

        // R5: exact spacing, R9 no false overrun
        half_div = 4'd1;
        hwr(1'b1, 1, 16'd120);
        b = nf;
        set_en(4'b0010);
        wait_done(3);
        set_en(4'b0);
        chk(fs_t[b+1] - fs_t[b] == 120, "R5 interval 1", fs_t[b+1] - fs_t[b], 120);
        chk(fs_t[b+2] - fs_t[b+1] == 120, "R5 interval 2", fs_t[b+2] - fs_t[b+1], 120);
        chk(ovr_flag == 0, "R9 no overrun at long period", ovr_flag, 0);
        repeat (200) @(negedge clk);

        // R6: period rewrite takes effect after next reload
        hwr(1'b1, 2, 16'd100);
        set_en(4'b0100);
        wait_done(1);
        b = nf - 1;
        hwr(1'b1, 2, 16'd160);
        wait_done(3);
        set_en(4'b0);
        chk(fs_t[b+1] - fs_t[b] == 100, "R6 old period", fs_t[b+1] - fs_t[b], 100);
        chk(fs_t[b+2] - fs_t[b+1] == 100, "R6 old period kept", fs_t[b+2] - fs_t[b+1], 100);
        chk(fs_t[b+3] - fs_t[b+2] == 160, "R6 new period", fs_t[b+3] - fs_t[b+2], 160);
        repeat (200) @(negedge clk);

        // R7: staging protects the frame in flight
        half_div = 4'd4;
        hwr(1'b1, 3, 16'd500);
        hwr(1'b0, 3, 16'h1111);
        b = ns;
        set_en(4'b1000);
        while (ns == b) @(negedge clk);
        repeat (20) @(negedge clk);
        hwr(1'b0, 3, 16'h2222);
        hwr(1'b0, 3, 16'h3333);
        wait_done(1);
        chk(fs_d[nf-1] == 16'h1111, "R7 in-flight frame unchanged", fs_d[nf-1], 16'h1111);
        wait_done(1);
        set_en(4'b0);
        chk(fs_d[nf-1] == 16'h3333, "R7 latest staged value next", fs_d[nf-1], 16'h3333);
        repeat (200) @(negedge clk);

        // R8: same-cycle expiry, lowest index first
        half_div = 4'd1;
        hwr(1'b1, 1, 16'd200);
        hwr(1'b1, 2, 16'd200);
        hwr(1'b0, 1, 16'h0101);
        hwr(1'b0, 2, 16'h0202);
        b = nf;
        set_en(4'b0110);
        wait_done(2);
        set_en(4'b0);
        chk(fs_ch[b] == 1, "R8 first served", fs_ch[b], 1);
        chk(fs_ch[b+1] == 2, "R8 second served", fs_ch[b+1], 2);
        chk(fs_t[b+1] - fr_t[b] == 3, "R8 back-to-back gap", fs_t[b+1] - fr_t[b], 3);
        chk(fs_d[b+1] == 16'h0202, "R8 second frame data", fs_d[b+1], 16'h0202);
        repeat (200) @(negedge clk);

        // R9: overrun set, sticky, cleared
        hwr(1'b1, 0, 16'd10);
        set_en(4'b0001);
        repeat (80) @(negedge clk);
        chk(ovr_flag == 4'b0001, "R9 overrun set", ovr_flag, 4'b0001);
        set_en(4'b0);
        repeat (300) @(negedge clk);
        chk(ovr_flag == 4'b0001, "R9 overrun sticky", ovr_flag, 4'b0001);
        @(negedge clk); ovr_clr = 4'b0001;
        @(negedge clk); ovr_clr = 4'b0;
        @(negedge clk);
        chk(ovr_flag == 0, "R9 overrun cleared", ovr_flag, 0);
        chk(ordbad == 0, "R3 R4 step order overall", ordbad, 0);

        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            nchk++; nfail++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule